// File: doc/BRIEF.md
# Payload Dewhitener and Checksum Verifier

This block sits after the error-correction decoder in a chirp-spread receive path. Payload bytes arrive one at a time. The block removes the whitening from each of them by XORing it with the full state byte of an 8-bit maximal-length shift register. It then passes the plain bytes on and folds them into a 16-bit CRC. Header bytes never reach this block: the controller starts it only once the header has been parsed and the payload length and CRC-enable flag are known.

Each packet opens with a one-cycle start strobe that carries the payload length (0 to 255) and the CRC-enable flag. The block then accepts that many payload bytes. When CRC is enabled, two checksum bytes follow. The checksum is formed without the usual zero augmentation. The CRC register only takes in the payload bytes up to the third-from-last. The last two plain bytes are XORed onto the result as a 16-bit word. At the end of every packet, a single-cycle done pulse reports whether the check passed.

Top module: `payload_dewhite_crc`

## Requirements
- R1: After reset, `out_valid` and `done` are low. Neither rises until a packet has been started.
- R2: Payload byte k (counted from 0) is output as `in_byte ^ S_k`, where S_0 = 0xFF and S_{k+1} = {S_k[6:0], S_k[7]^S_k[5]^S_k[4]^S_k[3]} (polynomial x^8+x^6+x^5+x^4+1). `out_valid` rises in the cycle after the byte is accepted.
- R3: Every `pkt_start` reloads the shift register to 0xFF and clears the CRC state. The first payload byte of each packet is therefore unwhitened with 0xFF.
- R4: With CRC enabled, the expected checksum is C ^ {P[N-2], P[N-1]}. C is the CRC (polynomial 0x1021, initial value 0, MSB first, no augmentation) over plain payload bytes P[0..N-3], and missing bytes count as zero when N < 2. The received checksum arrives high byte first. `done` pulses one cycle after the low byte is accepted, and `crc_ok` is 1 exactly when the two values match.
- R5: For a payload of zeros with the byte pair at positions N-4 and N-3 set to 0x00 0x01, 0x00 0x80, 0x01 0x00 or 0x80 0x00, the expected checksum is 0x1021, 0x9188, 0x3331 or 0x1B98 respectively. For an all-zero payload, the checksum is 0x0000.
- R6: With CRC disabled, no checksum bytes are taken. `done` pulses with `crc_ok`=1 one cycle after the last payload byte, or one cycle after `pkt_start` when the length is 0.
- R7: Checksum bytes are not unwhitened and never appear on `out_valid`/`out_byte`.
- R8: Bytes presented while no packet is open produce no output and no `done`.
- R9: A `pkt_start` aborts any open packet without a `done` for it. A byte presented in the same cycle as `pkt_start` is discarded.
- R10: Cycles with `in_valid` low do not advance the shift register, the CRC or the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | One-cycle packet open strobe |
| pkt_len | input | 8 | Payload byte count, sampled with `pkt_start` |
| crc_en | input | 1 | Payload checksum present, sampled with `pkt_start` |
| in_valid | input | 1 | `in_byte` holds a byte this cycle |
| in_byte | input | 8 | Decoded byte (payload or checksum) |
| out_valid | output | 1 | `out_byte` holds an unwhitened payload byte |
| out_byte | output | 8 | Unwhitened payload byte |
| done | output | 1 | One-cycle end-of-packet pulse |
| crc_ok | output | 1 | Check result, valid while `done` is high |

## Verification
Payloads of random bytes at lengths 0, 1, 2, 3 and 40 show whether the fold of the last two bytes works at the short-packet boundaries and in the long case. Flipping a single checksum bit shows that `crc_ok` actually depends on the comparison. The four single-pair vectors pin down the polynomial and the bit order, not just agreement with the bench's own model. Idle bytes, input gaps and a start strobe that cuts into an open packet separate proper packet framing from a block that simply counts every strobe.

// File: rtl/pdw_pkg.sv
// Shared types and the CRC byte step for the payload dewhitener.
package pdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_CHK_HI  = 2'd2,
        ST_CHK_LO  = 2'd3
    } seq_state_e;

    // One byte through a non-reflected CRC, MSB first, no augmentation.
    function automatic logic [15:0] crc_step(input logic [15:0] crc,
                                             input logic [7:0]  data,
                                             input logic [15:0] poly);
        logic [15:0] c;
        logic        fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/pdw_sequencer.sv
// Packet framing: tracks payload count and checksum phase.
// Assumes pkt_start is a single-cycle strobe; a start aborts any open packet.
module pdw_sequencer
    import pdw_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             crc_en,
    input  logic             in_valid,
    output logic             pay_take,
    output logic             chk_hi_take,
    output logic             chk_lo_take,
    output logic             end_nocrc
);

    seq_state_e       state_q;
    logic [LEN_W-1:0] remain_q;
    logic             crc_on_q;
    logic             last_pay;

    // Decode which kind of byte is consumed this cycle.
    always_comb begin
        pay_take    = !pkt_start && in_valid && (state_q == ST_PAYLOAD);
        chk_hi_take = !pkt_start && in_valid && (state_q == ST_CHK_HI);
        chk_lo_take = !pkt_start && in_valid && (state_q == ST_CHK_LO);
        last_pay    = pay_take && (remain_q == LEN_W'(1));
        end_nocrc   = (pkt_start && (pkt_len == '0) && !crc_en)
                    || (last_pay && !crc_on_q);
    end

    // Advance the framing state on start strobes and accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            crc_on_q <= 1'b0;
        end else if (pkt_start) begin
            remain_q <= pkt_len;
            crc_on_q <= crc_en;
            if (pkt_len != '0)  state_q <= ST_PAYLOAD;
            else if (crc_en)    state_q <= ST_CHK_HI;
            else                state_q <= ST_IDLE;
        end else if (in_valid) begin
            case (state_q)
                ST_PAYLOAD: begin
                    remain_q <= remain_q - LEN_W'(1);
                    if (remain_q == LEN_W'(1))
                        state_q <= crc_on_q ? ST_CHK_HI : ST_IDLE;
                end
                ST_CHK_HI: state_q <= ST_CHK_LO;
                ST_CHK_LO: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: the payload phase always has bytes left to take.
    a_r10_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD) |-> (remain_q != '0));

    // R8: nothing is consumed while idle.
    a_r8_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(pay_take || chk_hi_take || chk_lo_take));

endmodule

// File: rtl/pdw_whitener.sv
// Whitening generator: 8-bit Fibonacci shift register, x^8+x^6+x^5+x^4+1.
// Its whole state is XORed onto each payload byte; it steps once per byte.
module pdw_whitener #(
    parameter logic [7:0] SEED = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       step,
    input  logic [7:0] data_in,
    output logic [7:0] data_out
);

    logic [7:0] lfsr_q;
    logic       fb;

    // Feedback from taps 8,6,5,4 and the XOR onto the data.
    always_comb begin
        fb       = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
        data_out = data_in ^ lfsr_q;
    end

    // Reload at packet start, shift once per accepted payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) lfsr_q <= SEED;
        else if (step)         lfsr_q <= {lfsr_q[6:0], fb};
    end

    // R2: a maximal-length register seeded nonzero never reaches zero.
    a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 8'h00);

    // R10: the register holds when no byte is taken.
    a_r10_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step) |=> $stable(lfsr_q));

endmodule

// File: rtl/pdw_crc_fold.sv
// Checksum without augmentation: the CRC register absorbs each byte two
// positions late; the two newest bytes are XORed onto it as a word.
// A zero window pushed into a zero register leaves it zero, so short
// payloads need no special case.
module pdw_crc_fold
    import pdw_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        take,
    input  logic [7:0]  data_in,
    output logic [15:0] fold
);

    logic [15:0] crc_q;
    logic [7:0]  win_hi_q;
    logic [7:0]  win_lo_q;

    // Expected checksum for the bytes absorbed so far.
    always_comb fold = crc_q ^ {win_hi_q, win_lo_q};

    // Push the oldest window byte into the CRC and shift the window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            crc_q    <= '0;
            win_hi_q <= '0;
            win_lo_q <= '0;
        end else if (take) begin
            crc_q    <= crc_step(crc_q, win_hi_q, POLY);
            win_hi_q <= win_lo_q;
            win_lo_q <= data_in;
        end
    end

    // R3: a restart leaves an empty checksum.
    a_r3_clear_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> (fold == 16'h0000));

endmodule

// File: rtl/payload_dewhite_crc.sv
// Payload dewhitener and checksum verifier. Receives only payload and
// checksum bytes (headers bypass it). Outputs plain payload bytes one cycle
// after they are accepted, and a done pulse with the check result.
module payload_dewhite_crc
    import pdw_pkg::*;
#(
    parameter int          LEN_W = 8,
    parameter logic [7:0]  SEED  = 8'hFF,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             done,
    output logic             crc_ok
);

    logic        pay_take, chk_hi_take, chk_lo_take, end_nocrc;
    logic [7:0]  plain;
    logic [15:0] fold;
    logic [7:0]  chk_hi_q;
    logic        crc_on_q;

    pdw_sequencer #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_len    (pkt_len),
        .crc_en     (crc_en),
        .in_valid   (in_valid),
        .pay_take   (pay_take),
        .chk_hi_take(chk_hi_take),
        .chk_lo_take(chk_lo_take),
        .end_nocrc  (end_nocrc)
    );

    pdw_whitener #(.SEED(SEED)) u_wht (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pkt_start),
        .step    (pay_take),
        .data_in (in_byte),
        .data_out(plain)
    );

    pdw_crc_fold #(.POLY(POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(pkt_start),
        .take   (pay_take),
        .data_in(plain),
        .fold   (fold)
    );

    // Register the plain byte stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= pay_take;
            if (pay_take) out_byte <= plain;
        end
    end

    // Hold the checksum high byte and the packet's CRC mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hi_q <= '0;
            crc_on_q <= 1'b0;
        end else begin
            if (pkt_start)   crc_on_q <= crc_en;
            if (chk_hi_take) chk_hi_q <= in_byte;
        end
    end

    // Raise the end-of-packet pulse with its verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            done <= chk_lo_take || end_nocrc;
            if (chk_lo_take)    crc_ok <= ({chk_hi_q, in_byte} == fold);
            else if (end_nocrc) crc_ok <= 1'b1;
        end
    end

    // R2: an output byte always follows an input byte.
    a_r2_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R7: checksum bytes never show up on the output stream.
    a_r7_chk_not_output: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_hi_take || chk_lo_take) |-> !out_valid);

    // R6: a packet without checksum always reports pass.
    a_r6_nocrc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(chk_lo_take)) |-> crc_ok);

endmodule

// File: tb/payload_dewhite_crc_test.sv
module payload_dewhite_crc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0;
    logic [7:0] pkt_len = '0;
    logic       crc_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_valid, done, crc_ok;
    logic [7:0] out_byte;

    int errors = 0;
    int checks = 0;
    int observed = 0;
    logic [7:0] plain [256];

    logic [7:0] exp_b [$];
    string      exp_bt[$];
    logic       exp_ok[$];
    string      exp_ot[$];

    always #10 clk = ~clk;  // 50 MHz

    payload_dewhite_crc uut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_len(pkt_len),
        .crc_en(crc_en), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .done(done), .crc_ok(crc_ok)
    );

    function automatic logic [7:0] m_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare outputs as the design produces them.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            observed++;
            if (exp_b.size() == 0) check(0, "R8/R9", "unexpected byte", out_byte, 0);
            else begin
                automatic logic [7:0] e = exp_b.pop_front();
                automatic string t = exp_bt.pop_front();
                check(out_byte == e, t, "plain byte", out_byte, e);
            end
        end
        if (rst_n && done) begin
            observed++;
            if (exp_ok.size() == 0) check(0, "R8/R9", "unexpected done", crc_ok, 0);
            else begin
                automatic logic e = exp_ok.pop_front();
                automatic string t = exp_ot.pop_front();
                check(crc_ok == e, t, "crc verdict", crc_ok, e);
            end
        end
    end

    task automatic start(input int len, input bit ce, input bit with_byte);
        pkt_start = 1'b1; pkt_len = 8'(len); crc_en = ce;
        in_valid = with_byte; in_byte = 8'hA5;
        @(negedge clk);
        pkt_start = 1'b0; in_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Driver: whiten plain[], push expectations, send payload and checksum.
    task automatic run_pkt(input int len, input bit ce, input bit corrupt,
                           input bit gaps, input bit with_byte, input string tag,
                           input logic [15:0] force_chk, input bit use_force);
        logic [7:0]  s = 8'hFF;
        logic [15:0] c = '0;
        logic [7:0]  h = '0, l = '0;
        logic [15:0] chk;
        exp_ok.push_back(!corrupt); exp_ot.push_back(tag);
        start(len, ce, with_byte);
        for (int k = 0; k < len; k++) begin
            exp_b.push_back(plain[k]); exp_bt.push_back(tag);
            send(plain[k] ^ s);
            if (gaps) repeat (2) @(negedge clk);
            s = m_next(s);
            c = m_crc(c, h); h = l; l = plain[k];
        end
        if (ce) begin
            chk = use_force ? force_chk : (c ^ {h, l});
            if (corrupt) chk = chk ^ 16'h0400;
            send(chk[15:8]);
            send(chk[7:0]);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [15:0] model_chk(input int len);
        logic [15:0] c = '0;
        logic [7:0]  h = '0, l = '0;
        for (int k = 0; k < len; k++) begin
            c = m_crc(c, h); h = l; l = plain[k];
        end
        return c ^ {h, l};
    endfunction

    task automatic known_vec(input logic [7:0] b2, input logic [7:0] b3,
                             input logic [15:0] want);
        for (int k = 0; k < 6; k++) plain[k] = 8'h00;
        plain[2] = b2; plain[3] = b3;
        check(model_chk(6) == want, "R5", "bench model vector", model_chk(6), want);
        run_pkt(6, 1, 0, 0, 0, "R5", want, 1);
    endtask

    task automatic fill_rand(input int len);
        for (int k = 0; k < len; k++) plain[k] = 8'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && done == 0, "R1", "reset outputs", {out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(observed == 0, "R1", "quiet after reset", observed, 0);

        // R2/R4 long random payload, checksum on
        fill_rand(40); run_pkt(40, 1, 0, 0, 0, "R2/R4", '0, 0);
        // R3 second packet restarts the generator
        fill_rand(5);  run_pkt(5, 1, 0, 0, 0, "R3", '0, 0);
        // R4 short packets: lengths 0..3
        run_pkt(0, 1, 0, 0, 0, "R4", '0, 0);
        fill_rand(1);  run_pkt(1, 1, 0, 0, 0, "R4", '0, 0);
        fill_rand(2);  run_pkt(2, 1, 0, 0, 0, "R4", '0, 0);
        fill_rand(3);  run_pkt(3, 1, 0, 0, 0, "R4", '0, 0);
        // R4 corrupted checksum must fail
        fill_rand(12); run_pkt(12, 1, 1, 0, 0, "R4", '0, 0);
        // R5 fixed vectors and all-zero payload
        known_vec(8'h00, 8'h01, 16'h1021);
        known_vec(8'h00, 8'h80, 16'h9188);
        known_vec(8'h01, 8'h00, 16'h3331);
        known_vec(8'h80, 8'h00, 16'h1B98);
        for (int k = 0; k < 8; k++) plain[k] = 8'h00;
        run_pkt(8, 1, 0, 0, 0, "R5", 16'h0000, 1);
        // R6 checksum disabled, including length 0; R7 via the monitor
        fill_rand(7);  run_pkt(7, 0, 0, 0, 0, "R6", '0, 0);
        run_pkt(0, 0, 0, 0, 0, "R6", '0, 0);
        // R7: no extra bytes appear after a checksum packet
        snap = observed;
        fill_rand(4);  run_pkt(4, 1, 0, 0, 0, "R7", '0, 0);
        check(observed - snap == 5, "R7", "outputs for 4-byte packet", observed - snap, 5);
        // R8 idle bytes ignored
        snap = observed;
        send(8'h11); send(8'h22); send(8'h33);
        repeat (3) @(negedge clk);
        check(observed == snap, "R8", "idle bytes produce nothing", observed - snap, 0);
        // R9 abort: packet A cut after two bytes, B starts with a stray byte
        fill_rand(2);
        start(5, 1, 0);
        exp_b.push_back(plain[0]); exp_bt.push_back("R9");
        send(plain[0] ^ 8'hFF);
        exp_b.push_back(plain[1]); exp_bt.push_back("R9");
        send(plain[1] ^ m_next(8'hFF));
        fill_rand(6);  run_pkt(6, 1, 0, 0, 1, "R9", '0, 0);
        // R10 gaps between bytes
        fill_rand(9);  run_pkt(9, 1, 0, 1, 0, "R10", '0, 0);

        repeat (5) @(negedge clk);
        check(exp_b.size() == 0, "R2", "bytes left unmatched", exp_b.size(), 0);
        check(exp_ok.size() == 0, "R4", "verdicts left unmatched", exp_ok.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule